// File: doc/BRIEF.md
# Programmable Loop Divider with Phase-Frequency Detector

This block is the digital core of a frequency-synthesis loop. One of two oscillator event streams (a low-band and a high-band path) is picked by a band bit. The picked stream is counted down by a programmable modulus. Each terminal count makes a one-cycle divided pulse. That pulse is compared against a reference pulse in a phase-frequency detector, which drives two exclusive pump commands and a high-impedance indication toward an external charge pump.

The oscillator inputs are modelled as single-cycle enables in the block's clock domain. The divided pulse and the reference pulse are events, not a data stream. For that reason every pin is a plain control or status signal: there is no valid/ready pairing and no back-pressure. An event that arrives is acted on in the cycle it is sampled.

The divide word is read only when the count expires. A controller can therefore rewrite it at any time without disturbing the division in progress. The pump polarity is set for an inverting loop filter: a divided signal that runs ahead of the reference produces a source command.

Top module: `loop_divider_pfd`

## Requirements
- R1: While reset is held and in the first cycle after it, `div_out`, `pump_src` and `pump_snk` are 0 and `pump_hiz` is 1.
- R2: With a fixed word N, `div_out` pulses on the first selected oscillator event after reset. After that it pulses on every (N+1)-th selected event. Each pulse is one clock wide and appears in the cycle after the event that was sampled.
- R3: When `band_fm` is 1, only `fm_tick` advances the divider. When it is 0, only `am_tick` does. Events on the unselected input have no effect on `div_out`.
- R4: A new `div_word` takes effect only at the next terminal count. The division already under way completes with the old modulus.
- R5: In the cycle `band_fm` changes value, no event is counted and the counter is cleared. The first selected event afterwards produces a divided pulse, and the next pulse follows N+1 events later.
- R6: When a divided pulse comes before the reference pulse, `pump_src` is 1 from the cycle after the divided pulse up to and including the cycle in which the reference pulse is present. Its width in cycles equals the spacing of the two events.
- R7: When a reference pulse comes before the divided pulse, `pump_snk` is 1 under the same timing rule as R6, with the two events swapped.
- R8: A divided pulse and a reference pulse in the same cycle leave both pump commands at 0.
- R9: `pump_src` and `pump_snk` are never 1 together, and `pump_hiz` is 1 exactly when neither is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| am_tick | input | 1 | Low-band oscillator event enable |
| fm_tick | input | 1 | High-band oscillator event enable |
| band_fm | input | 1 | 1 selects `fm_tick`, 0 selects `am_tick` |
| div_word | input | 14 | Divide word N; the modulus is N+1 |
| ref_tick | input | 1 | Reference event, one cycle wide |
| div_out | output | 1 | Divided pulse, one cycle per terminal count |
| pump_src | output | 1 | Pump source command (divided signal ahead) |
| pump_snk | output | 1 | Pump sink command (reference ahead) |
| pump_hiz | output | 1 | Pump held at high impedance |

## Verification
The sweep walks every word from 0 to 7 on both bands while the unselected oscillator input fires every cycle. An off-by-one modulus would put pulses in the wrong place. A leaky band multiplexer would add pulses. A word rewritten during a count must not shorten that count; a design that reloaded on every write would put the next pulse early. A band change must clear the counter; a design that only swapped the source would pulse two events late. The detector is driven with reference offsets from -5 to +5 cycles. Inverted polarity, a pulse width off by one, or a stray command when both events coincide would each show up in the measured high time of the pump outputs.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  parameter int unsigned DIV_W_DEF = 14;
  parameter int unsigned NSRC_DEF  = 2;

  typedef enum logic [1:0] {
    PUMP_HIZ = 2'b00,
    PUMP_SRC = 2'b01,
    PUMP_SNK = 2'b10
  } pump_cmd_e;
endpackage

// File: rtl/lpd_src_sel.sv
module lpd_src_sel #(
  parameter int unsigned NSRC  = 2,
  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  osc_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic             restart
);
  generate
    if (NSRC == 1) begin : g_single
      assign tick    = osc_tick[0];
      assign restart = 1'b0;
    end else begin : g_multi
      logic [SEL_W-1:0] sel_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel;
      end

      // A change of source clears the divider and swallows this cycle's event
      assign restart = (sel != sel_q);
      assign tick    = osc_tick[sel] & ~restart;
    end
  endgenerate
endmodule

// File: rtl/lpd_mod_counter.sv
module lpd_mod_counter #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] word,
  output logic         term
);
  logic [W-1:0] cnt;
  logic         at_zero;

  assign at_zero = (cnt == '0);

  // The word is sampled only when the count expires, so a write mid-count
  // cannot shorten or stretch the division in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      term <= 1'b0;
    end else begin
      term <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (tick) begin
        if (at_zero) begin
          cnt  <= word;
          term <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lpd_pfd.sv
module lpd_pfd
  import lpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_ev,
  input  logic      div_ev,
  output pump_cmd_e cmd
);
  logic ref_f, div_f;
  logic ref_n, div_n;

  assign ref_n = ref_f | ref_ev;
  assign div_n = div_f | div_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_f <= 1'b0;
      div_f <= 1'b0;
    end else if (ref_n && div_n) begin
      ref_f <= 1'b0;
      div_f <= 1'b0;
    end else begin
      ref_f <= ref_n;
      div_f <= div_n;
    end
  end

  always_comb begin
    unique case ({ref_f, div_f})
      2'b01:   cmd = PUMP_SRC;
      2'b10:   cmd = PUMP_SNK;
      default: cmd = PUMP_HIZ;
    endcase
  end
endmodule

// File: rtl/loop_divider_pfd.sv
module loop_divider_pfd
  import lpd_pkg::*;
#(
  parameter int unsigned DIV_W = lpd_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             am_tick,
  input  logic             fm_tick,
  input  logic             band_fm,
  input  logic [DIV_W-1:0] div_word,
  input  logic             ref_tick,
  output logic             div_out,
  output logic             pump_src,
  output logic             pump_snk,
  output logic             pump_hiz
);
  localparam int unsigned NSRC = lpd_pkg::NSRC_DEF;

  logic      osc_ev;
  logic      restart;
  pump_cmd_e cmd;

  lpd_src_sel #(.NSRC(NSRC)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick ({fm_tick, am_tick}),
    .sel      (band_fm),
    .tick     (osc_ev),
    .restart  (restart)
  );

  lpd_mod_counter #(.W(DIV_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (osc_ev),
    .restart (restart),
    .word    (div_word),
    .term    (div_out)
  );

  lpd_pfd u_pfd (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_ev (ref_tick),
    .div_ev (div_out),
    .cmd    (cmd)
  );

  assign pump_src = (cmd == PUMP_SRC);
  assign pump_snk = (cmd == PUMP_SNK);
  assign pump_hiz = (cmd == PUMP_HIZ);
endmodule

// File: rtl/lpd_chk.sv
module lpd_chk (
  input logic clk,
  input logic rst_n,
  input logic band_fm,
  input logic ref_tick,
  input logic div_out,
  input logic pump_src,
  input logic pump_snk
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R9
  excl_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_src && pump_snk));

  // R6
  src_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(pump_src)) |-> ($past(div_out) && !$past(ref_tick)));

  // R7
  snk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(pump_snk)) |-> ($past(ref_tick) && !$past(div_out)));

  // R5
  band_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && (band_fm != $past(band_fm))) |=> !div_out);

  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !pump_src && !pump_snk && div_out && ref_tick) |=> (!pump_src && !pump_snk));
endmodule

bind loop_divider_pfd lpd_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .band_fm  (band_fm),
  .ref_tick (ref_tick),
  .div_out  (div_out),
  .pump_src (pump_src),
  .pump_snk (pump_snk)
);

// File: tb/loop_divider_pfd_tb.sv
module loop_divider_pfd_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        am_tick = 1'b0, fm_tick = 1'b0, band_fm = 1'b0, ref_tick = 1'b0;
  logic [13:0] div_word = '0;
  logic        div_out, pump_src, pump_snk, pump_hiz;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  loop_divider_pfd u_dut (
    .clk(clk), .rst_n(rst_n), .am_tick(am_tick), .fm_tick(fm_tick),
    .band_fm(band_fm), .div_word(div_word), .ref_tick(ref_tick),
    .div_out(div_out), .pump_src(pump_src), .pump_snk(pump_snk), .pump_hiz(pump_hiz)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit band, input int n);
    @(negedge clk);
    rst_n = 1'b0; am_tick = 0; fm_tick = 0; ref_tick = 0;
    band_fm = band; div_word = 14'(n);
    repeat (3) @(negedge clk);
    check(!div_out && !pump_src && !pump_snk && pump_hiz, "R1 in reset",
          {div_out, pump_src, pump_snk, pump_hiz}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!div_out && !pump_src && !pump_snk && pump_hiz, "R1 after reset",
          {div_out, pump_src, pump_snk, pump_hiz}, 1);
  endtask

  // One selected event followed by an idle cycle; the other input fires throughout.
  task automatic tick_and_check(input int exp, input string req);
    if (band_fm) begin fm_tick = 1; am_tick = 1; end
    else         begin am_tick = 1; fm_tick = 1; end
    @(negedge clk);
    check(div_out == exp[0], req, div_out, exp);
    if (band_fm) fm_tick = 0; else am_tick = 0;
    @(negedge clk);
    check(div_out == 1'b0, "R2 pulse width", div_out, 0);
  endtask

  task automatic pfd_case(input int d);
    int src_cnt = 0, snk_cnt = 0;
    for (int c = 0; c < 16; c++) begin
      if (c > 0) begin
        src_cnt += pump_src;
        snk_cnt += pump_snk;
        check(!(pump_src && pump_snk) && (pump_hiz == !(pump_src || pump_snk)),
              "R9 exclusive", {pump_src, pump_snk, pump_hiz}, 0);
      end
      am_tick  = (c == 4);
      ref_tick = (c == 5 + d);
      @(negedge clk);
    end
    am_tick = 0; ref_tick = 0;
    if (d > 0) begin
      check(src_cnt == d, "R6 source width", src_cnt, d);
      check(snk_cnt == 0, "R6 no sink", snk_cnt, 0);
    end else if (d < 0) begin
      check(snk_cnt == -d, "R7 sink width", snk_cnt, -d);
      check(src_cnt == 0, "R7 no source", src_cnt, 0);
    end else begin
      check(src_cnt == 0 && snk_cnt == 0, "R8 coincident", src_cnt + snk_cnt, 0);
    end
  endtask

  initial begin
    // R2 / R3: sweep modulus on both bands with the other input active
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 8; n++) begin
        do_reset(b[0], n);
        for (int k = 0; k < 24; k++)
          tick_and_check(((k % (n + 1)) == 0) ? 1 : 0, b ? "R2 R3 fm band" : "R2 R3 am band");
        am_tick = 0; fm_tick = 0;
      end
    end

    // R4: word rewritten mid-count; pulses expected at events 0, 4, 10
    do_reset(1'b0, 3);
    for (int k = 0; k < 12; k++) begin
      if (k == 2) div_word = 14'd5;
      tick_and_check((k == 0 || k == 4 || k == 10) ? 1 : 0, "R4 deferred word");
    end

    // R5: band change clears the counter; new band pulses at events 0 and 5
    do_reset(1'b0, 4);
    for (int k = 0; k < 3; k++) tick_and_check((k == 0) ? 1 : 0, "R5 before switch");
    am_tick = 0; fm_tick = 0;
    band_fm = 1'b1;
    @(negedge clk);
    check(div_out == 1'b0, "R5 switch cycle", div_out, 0);
    for (int k = 0; k < 8; k++) tick_and_check((k == 0 || k == 5) ? 1 : 0, "R5 after switch");
    am_tick = 0; fm_tick = 0;

    // R6 / R7 / R8: detector with reference offsets, modulus 1
    do_reset(1'b0, 0);
    for (int d = -5; d <= 5; d++) pfd_case(d);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired (R1 through R9 incomplete) actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule